// File: doc/BRIEF.md
# Indexed Effective Address Unit

This unit forms the data address for indexed memory operations in a 16-bit address space. The caller presents decoded mode fields, the current register values and a one-cycle `start` strobe. The unit picks a base register (X, Y, SP or PC) and adds an offset to it. The offset can be a sign-extended constant, an accumulator, or an automatic step of 1 to 8. In step mode the base register is moved up or down, before or after the address is taken, and the new register value comes back on a write-back port.

The two indirect modes add a 16-bit constant or the double accumulator to the base. They then fetch a 16-bit pointer through a byte-wide read port with a valid/ready handshake. The pointer becomes the final address. The direct modes finish one cycle after `start`. The indirect modes finish one cycle after the second byte is accepted. `done` pulses for one cycle, and `eaOut` and the write-back fields are valid while it is high. Instruction decoding happens upstream.

Top module: `ea_index_unit`

## Requirements
- R1: After reset, `done`, `baseWrEn`, `memReq` and `busy` are low and `eaOut` is zero.
- R2: Mode code 0 (constant offset): `eaOut` is the base plus the constant, with no write-back. The constant's width is picked by `constWidth`: 0 uses `constVal[4:0]`, 1 uses `constVal[8:0]`, 2 uses all 16 bits. Each is sign-extended.
- R3: `baseSel` picks the base register: 0 is X, 1 is Y, 2 is SP, 3 is PC. On write-back, `baseWrSel` carries the same code.
- R4: Mode code 1 (accumulator offset): `accSel` 0 adds A and 1 adds B, each zero-extended. `accSel` 2 adds D = {A,B}. There is no write-back.
- R5: Mode code 2 with `autoPre`=1 (pre-modify): `eaOut` equals the modified base. `baseWrEn` is high with `done`, and `baseWrData` holds that same modified value.
- R6: Mode code 2 with `autoPre`=0 (post-modify): `eaOut` equals the unmodified base. The modified value is written back.
- R7: The step amount is `autoAmt`+1, giving 1 to 8. `autoDec`=1 subtracts the step and `autoDec`=0 adds it.
- R8: All address sums and steps wrap modulo 2^16.
- R9: In modes 0 to 2, `done` is high exactly one cycle after `start` is sampled, and `memReq` stays low.
- R10: The indirect modes are code 3 (base plus full 16-bit `constVal`) and code 4 (base plus D). The unit reads the high byte at the sum and the low byte at sum+1. `eaOut` is {high,low} and there is no write-back.
- R11: While `memReq` is high and `memReady` is low, `memReq` and `memAddr` hold steady. `done` rises one cycle after the second accepted byte.
- R12: A `start` pulse while `busy` is high is ignored. It neither changes the pending result nor produces an extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation |
| mode | input | 3 | Mode code 0..4 (see R2, R4, R5, R10) |
| baseSel | input | 2 | Base register code |
| constVal | input | 16 | Raw constant offset |
| constWidth | input | 2 | Constant width code |
| accSel | input | 2 | Accumulator offset code |
| autoAmt | input | 3 | Step amount minus one |
| autoDec | input | 1 | Step direction, 1 subtracts |
| autoPre | input | 1 | 1 pre-modify, 0 post-modify |
| regX | input | 16 | Index register X |
| regY | input | 16 | Index register Y |
| regSp | input | 16 | Stack pointer |
| regPc | input | 16 | Program counter |
| accA | input | 8 | Accumulator A (high byte of D) |
| accB | input | 8 | Accumulator B (low byte of D) |
| memReq | output | 1 | Pointer byte read valid |
| memAddr | output | 16 | Pointer byte read address |
| memReady | input | 1 | Read accepted, data valid |
| memData | input | 8 | Read data |
| eaOut | output | 16 | Effective address |
| baseWrData | output | 16 | Updated base register value |
| baseWrSel | output | 2 | Register code to update |
| baseWrEn | output | 1 | Write-back enable |
| done | output | 1 | Result valid strobe |
| busy | output | 1 | Indirect read in progress |

## Verification
Random operations cover every mode with all base codes, widths, accumulator codes, step amounts and directions. Register values are drawn so that sign extension and zero extension give different sums, and wrap-around happens often.

Directed cases tell a 5-bit constant apart from a 9-bit constant with the same low bits, and pre-modify apart from post-modify on one base value. They also compare an increment at 0xFFFF with a decrement at 0x0000. In the indirect reads, the ready signal stalls at random, and a bench memory returns address-dependent bytes so that a swapped pointer byte order is visible. A `start` pulse inserted during a fetch tells ignored requests apart from accepted ones.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    MD_CONST    = 3'd0,
    MD_ACC      = 3'd1,
    MD_AUTO     = 3'd2,
    MD_IND_CONST = 3'd3,
    MD_IND_ACCD = 3'd4
  } eaMode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RDHI = 2'd1,
    ST_RDLO = 2'd2
  } eaState_e;

  typedef struct packed {
    logic loadDirect;
    logic loadPtr;
    logic capHi;
    logic finishInd;
    logic readLo;
  } eaStrobe_t;

  function automatic logic isIndirect(input logic [2:0] m);
    return (m == MD_IND_CONST) || (m == MD_IND_ACCD);
  endfunction
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] mode,
  input  logic       memReady,
  output eaStrobe_t  strb,
  output logic       memReq,
  output logic       busy
);
  eaState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    strb = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (isIndirect(mode)) begin
            strb.loadPtr = 1'b1;
            stateNxt = ST_RDHI;
          end else begin
            strb.loadDirect = 1'b1;
          end
        end
      end
      ST_RDHI: begin
        if (memReady) begin
          strb.capHi = 1'b1;
          stateNxt = ST_RDLO;
        end
      end
      ST_RDLO: begin
        strb.readLo = 1'b1;
        if (memReady) begin
          strb.finishInd = 1'b1;
          stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign memReq = (state != ST_IDLE);
  assign busy   = (state != ST_IDLE);

  // R12: once a fetch is under way, only the accepted low byte ends it
  a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(strb.readLo && memReady)) |=> busy);

  // R10: a started indirect operation always begins with the high byte
  a_r10_hi_first: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && isIndirect(mode)) |=> (state == ST_RDHI));
endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int AMT_W  = 3,
  parameter int NBASE  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  eaStrobe_t                strb,
  input  logic [2:0]               mode,
  input  logic [$clog2(NBASE)-1:0] baseSel,
  input  logic [ADDR_W-1:0]        constVal,
  input  logic [1:0]               constWidth,
  input  logic [1:0]               accSel,
  input  logic [AMT_W-1:0]         autoAmt,
  input  logic                     autoDec,
  input  logic                     autoPre,
  input  logic [ADDR_W-1:0]        baseVals [NBASE],
  input  logic [BYTE_W-1:0]        accA,
  input  logic [BYTE_W-1:0]        accB,
  input  logic [BYTE_W-1:0]        memData,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [ADDR_W-1:0]        eaOut,
  output logic [ADDR_W-1:0]        baseWrData,
  output logic [$clog2(NBASE)-1:0] baseWrSel,
  output logic                     baseWrEn,
  output logic                     done
);
  localparam int SEL_W  = $clog2(NBASE);
  localparam int SHORT_W = 5;
  localparam int MID_W   = 9;

  logic [ADDR_W-1:0] baseVal, constExt, accExt, stepVal, modBase;
  logic [ADDR_W-1:0] sumVal, eaNext;
  logic              wrNext;
  logic [ADDR_W-1:0] ptrReg;
  logic [BYTE_W-1:0] hiReg;

  assign baseVal = baseVals[baseSel];

  always_comb begin
    case (constWidth)
      2'd0:    constExt = {{(ADDR_W-SHORT_W){constVal[SHORT_W-1]}}, constVal[SHORT_W-1:0]};
      2'd1:    constExt = {{(ADDR_W-MID_W){constVal[MID_W-1]}}, constVal[MID_W-1:0]};
      default: constExt = constVal;
    endcase
  end

  always_comb begin
    case (accSel)
      2'd0:    accExt = {{(ADDR_W-BYTE_W){1'b0}}, accA};
      2'd1:    accExt = {{(ADDR_W-BYTE_W){1'b0}}, accB};
      default: accExt = {accA, accB};
    endcase
  end

  assign stepVal = {{(ADDR_W-AMT_W){1'b0}}, autoAmt} + 1'b1;
  assign modBase = autoDec ? (baseVal - stepVal) : (baseVal + stepVal);

  always_comb begin
    wrNext = 1'b0;
    sumVal = baseVal + constExt;
    case (mode)
      MD_ACC:       sumVal = baseVal + accExt;
      MD_AUTO:      sumVal = baseVal + constExt;
      MD_IND_CONST: sumVal = baseVal + constVal;
      MD_IND_ACCD:  sumVal = baseVal + {accA, accB};
      default:      sumVal = baseVal + constExt;
    endcase
    if (mode == MD_AUTO) begin
      eaNext = autoPre ? modBase : baseVal;
      wrNext = 1'b1;
    end else begin
      eaNext = sumVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg     <= '0;
      hiReg      <= '0;
      eaOut      <= '0;
      baseWrData <= '0;
      baseWrSel  <= '0;
      baseWrEn   <= 1'b0;
      done       <= 1'b0;
    end else begin
      done     <= strb.loadDirect | strb.finishInd;
      baseWrEn <= strb.loadDirect & wrNext;
      if (strb.loadDirect) begin
        eaOut      <= eaNext;
        baseWrData <= modBase;
        baseWrSel  <= baseSel;
      end
      if (strb.loadPtr)   ptrReg <= sumVal;
      if (strb.capHi)     hiReg  <= memData;
      if (strb.finishInd) eaOut  <= {hiReg, memData};
    end
  end

  assign memAddr = strb.readLo ? (ptrReg + 1'b1) : ptrReg;

  // R10: the low pointer byte is fetched one address above the high byte
  a_r10_lo_after_hi: assert property (@(posedge clk) disable iff (!rstN)
    strb.capHi |=> (memAddr == $past(memAddr) + 1'b1));

  // R5: a write-back is only ever offered together with a result
  a_r5_wren_with_done: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |-> done);

  logic unusedSel;
  assign unusedSel = ^SEL_W;
endmodule

// File: rtl/ea_index_unit.sv
module ea_index_unit
  import ea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int AMT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [1:0]        baseSel,
  input  logic [ADDR_W-1:0] constVal,
  input  logic [1:0]        constWidth,
  input  logic [1:0]        accSel,
  input  logic [AMT_W-1:0]  autoAmt,
  input  logic              autoDec,
  input  logic              autoPre,
  input  logic [ADDR_W-1:0] regX,
  input  logic [ADDR_W-1:0] regY,
  input  logic [ADDR_W-1:0] regSp,
  input  logic [ADDR_W-1:0] regPc,
  input  logic [BYTE_W-1:0] accA,
  input  logic [BYTE_W-1:0] accB,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memReady,
  input  logic [BYTE_W-1:0] memData,
  output logic [ADDR_W-1:0] eaOut,
  output logic [ADDR_W-1:0] baseWrData,
  output logic [1:0]        baseWrSel,
  output logic              baseWrEn,
  output logic              done,
  output logic              busy
);
  localparam int NBASE = 4;

  eaStrobe_t         strb;
  logic [ADDR_W-1:0] baseVals [NBASE];

  assign baseVals[0] = regX;
  assign baseVals[1] = regY;
  assign baseVals[2] = regSp;
  assign baseVals[3] = regPc;

  ea_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .memReady(memReady), .strb(strb), .memReq(memReq), .busy(busy)
  );

  ea_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .AMT_W(AMT_W), .NBASE(NBASE)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .mode(mode), .baseSel(baseSel),
    .constVal(constVal), .constWidth(constWidth), .accSel(accSel),
    .autoAmt(autoAmt), .autoDec(autoDec), .autoPre(autoPre),
    .baseVals(baseVals), .accA(accA), .accB(accB), .memData(memData),
    .memAddr(memAddr), .eaOut(eaOut), .baseWrData(baseWrData),
    .baseWrSel(baseWrSel), .baseWrEn(baseWrEn), .done(done)
  );

  // R9: a direct-mode start yields a result on the next cycle
  a_r9_direct_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !isIndirect(mode)) |=> (done && !memReq));

  // R11: a stalled read keeps its request and address
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr)));

  // R12: a result is never reported while a fetch is still open
  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: tb/tb_ea_index_unit.sv
module tb_ea_index_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [2:0]  mode;
  logic [1:0]  baseSel, constWidth, accSel;
  logic [15:0] constVal, regX, regY, regSp, regPc;
  logic [2:0]  autoAmt;
  logic        autoDec, autoPre;
  logic [7:0]  accA, accB, memData;
  logic        memReq, memReady, baseWrEn, done, busy;
  logic [15:0] memAddr, eaOut, baseWrData;
  logic [1:0]  baseWrSel;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ea_index_unit dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .baseSel(baseSel),
    .constVal(constVal), .constWidth(constWidth), .accSel(accSel),
    .autoAmt(autoAmt), .autoDec(autoDec), .autoPre(autoPre),
    .regX(regX), .regY(regY), .regSp(regSp), .regPc(regPc),
    .accA(accA), .accB(accB), .memReq(memReq), .memAddr(memAddr),
    .memReady(memReady), .memData(memData), .eaOut(eaOut),
    .baseWrData(baseWrData), .baseWrSel(baseWrSel), .baseWrEn(baseWrEn),
    .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  function automatic logic [15:0] pickBase(input logic [1:0] s);
    case (s)
      2'd0: return regX;
      2'd1: return regY;
      2'd2: return regSp;
      default: return regPc;
    endcase
  endfunction

  function automatic logic [15:0] expConst();
    case (constWidth)
      2'd0: return {{11{constVal[4]}}, constVal[4:0]};
      2'd1: return {{7{constVal[8]}}, constVal[8:0]};
      default: return constVal;
    endcase
  endfunction

  function automatic logic [15:0] expAcc();
    case (accSel)
      2'd0: return {8'h00, accA};
      2'd1: return {8'h00, accB};
      default: return {accA, accB};
    endcase
  endfunction

  function automatic logic [15:0] expMod();
    logic [15:0] st = 16'(autoAmt) + 16'd1;
    return autoDec ? pickBase(baseSel) - st : pickBase(baseSel) + st;
  endfunction

  function automatic logic [15:0] expPtr();
    if (mode == 3'd3) return pickBase(baseSel) + constVal;
    return pickBase(baseSel) + {accA, accB};
  endfunction

  // direct modes 0..2; inputs already set
  task automatic runDirect(input string tag);
    logic [15:0] eExp;
    logic        wExp;
    wExp = 1'b0;
    case (mode)
      3'd0: eExp = pickBase(baseSel) + expConst();
      3'd1: eExp = pickBase(baseSel) + expAcc();
      default: begin
        eExp = autoPre ? expMod() : pickBase(baseSel);
        wExp = 1'b1;
      end
    endcase
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1, {tag, " R9 done"}, int'(done), 1);
    chk(memReq === 1'b0, {tag, " R9 memReq"}, int'(memReq), 0);
    chk(eaOut === eExp, {tag, " ea"}, int'(eaOut), int'(eExp));
    chk(baseWrEn === wExp, {tag, " wren"}, int'(baseWrEn), int'(wExp));
    if (wExp) begin
      chk(baseWrData === expMod(), {tag, " R7 wrdata"}, int'(baseWrData), int'(expMod()));
      chk(baseWrSel === baseSel, {tag, " R3 wrsel"}, int'(baseWrSel), int'(baseSel));
    end
    @(negedge clk);
    chk(done === 1'b0, {tag, " R9 pulse"}, int'(done), 0);
  endtask

  // indirect modes 3,4 with random stalls; optional start during fetch
  task automatic runIndirect(input string tag, input bit poke);
    logic [15:0] p, a, hold;
    int hs, cyc, stalled;
    p = expPtr();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    hs = 0; cyc = 0; stalled = 0; hold = '0;
    while (hs < 2 && cyc < 200) begin
      a = (hs == 0) ? p : p + 16'd1;
      chk(memReq === 1'b1, {tag, " R10 req"}, int'(memReq), 1);
      chk(memAddr === a, {tag, " R10 addr"}, int'(memAddr), int'(a));
      if (stalled != 0)
        chk(memAddr === hold, {tag, " R11 hold"}, int'(memAddr), int'(hold));
      memData  = memByte(memAddr);
      memReady = ($urandom % 3) != 0;
      if (poke && cyc == 0) begin
        start = 1'b1;
        mode = 3'd0;
      end else begin
        start = 1'b0;
      end
      hold = memAddr;
      stalled = memReady ? 0 : 1;
      @(negedge clk);
      if (memReady) hs++;
      cyc++;
    end
    memReady = 1'b0;
    start = 1'b0;
    chk(done === 1'b1, {tag, " R11 done"}, int'(done), 1);
    chk(eaOut === {memByte(p), memByte(p + 16'd1)}, {tag, " R10 ea"},
        int'(eaOut), int'({memByte(p), memByte(p + 16'd1)}));
    chk(baseWrEn === 1'b0, {tag, " R10 nowr"}, int'(baseWrEn), 0);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, {tag, " R12 no extra"}, int'(done), 0);
  endtask

  task automatic randFields();
    baseSel = 2'($urandom); constVal = 16'($urandom);
    constWidth = 2'($urandom % 3); accSel = 2'($urandom % 3);
    autoAmt = 3'($urandom); autoDec = 1'($urandom); autoPre = 1'($urandom);
    regX = 16'($urandom); regY = 16'($urandom); regSp = 16'($urandom);
    regPc = 16'($urandom); accA = 8'($urandom); accB = 8'($urandom);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; start = 1'b0; mode = 3'd0; memReady = 1'b0; memData = '0;
    randFields();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done === 1'b0 && baseWrEn === 1'b0, "R1 strobes", int'(done), 0);
    chk(memReq === 1'b0 && busy === 1'b0, "R1 idle", int'(memReq), 0);
    chk(eaOut === 16'h0, "R1 ea", int'(eaOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: 5-bit vs 9-bit with same low bits
    regX = 16'h1000; baseSel = 2'd0; mode = 3'd0;
    constVal = 16'h0010; constWidth = 2'd0; runDirect("R2 w5 neg");
    constWidth = 2'd1; runDirect("R2 w9 pos");
    constVal = 16'h0140; runDirect("R2 w9 neg");
    constVal = 16'h8000; constWidth = 2'd2; runDirect("R2 w16");
    // R3: each base code
    regY = 16'h2222; regSp = 16'h3333; regPc = 16'h4444; constWidth = 2'd0; constVal = 16'h0001;
    for (int s = 0; s < 4; s++) begin baseSel = 2'(s); runDirect("R3 base"); end
    // R4: accumulators
    mode = 3'd1; accA = 8'hF0; accB = 8'h81; baseSel = 2'd1;
    for (int s = 0; s < 3; s++) begin accSel = 2'(s); runDirect("R4 acc"); end
    // R5 R6 R7 R8: pre/post, wrap edges
    mode = 3'd2; baseSel = 2'd2; regSp = 16'hFFFF; autoAmt = 3'd0; autoDec = 1'b0;
    autoPre = 1'b1; runDirect("R5 R8 pre inc wrap");
    autoPre = 1'b0; runDirect("R6 post inc");
    regSp = 16'h0000; autoAmt = 3'd7; autoDec = 1'b1;
    autoPre = 1'b1; runDirect("R7 R8 pre dec8 wrap");
    autoPre = 1'b0; runDirect("R6 post dec");
    // R10 R11: indirect forms
    mode = 3'd3; baseSel = 2'd0; regX = 16'hFFF0; constVal = 16'h0020;
    runIndirect("R10 ind const", 1'b0);
    mode = 3'd4; accA = 8'h12; accB = 8'h34; runIndirect("R10 ind D", 1'b0);
    // R12: start while busy
    mode = 3'd3; constVal = 16'h0FFF; runIndirect("R12 poke", 1'b1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      randFields();
      mode = 3'($urandom % 5);
      if (mode >= 3'd3) runIndirect("rnd R10", 1'($urandom % 4 == 0));
      else runDirect("rnd R2 R4 R5");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule